// File: doc/BRIEF.md
# Slow-Control Channel Rate Acquisition

This block follows the rate pointer of the slow control channel. Once per hyperframe it takes a 3-bit pointer from the low bits of a control byte. It adopts a new pointer value only after that value has stayed the same over a run of consecutive hyperframes. The adopted value is published as the accepted rate code, and a change pulse marks the cycle in which it is adopted. Software can preload a starting code before the link begins dynamic updates.

From the accepted code and the current link line rate, the block derives three things:
- the channel bit rate in kbps;
- whether the channel is present;
- whether the line rate is too slow for the requested code.

The top code always means "the highest rate this line rate can carry".

All pins are plain control and status signals, and the block has no stream interface. The hyperframe strobe is a one-cycle qualifier that the block always accepts, so there is no back-pressure. Strobes may arrive in back-to-back cycles.

Top module: `slowctl_rate_acq`

## Requirements
- R1: The pointer is bits [2:0] of `ctrl_byte`, sampled only in cycles where `hf_strobe` is high. Bits [7:3] have no effect.
- R2: After reset, `acc_code` is 0 and `chan_en`, `rate_kbps`, `unsupported` and `change_pulse` are all 0.
- R3: A pointer different from `acc_code` is adopted only on its PERSIST-th consecutive identical strobe (default 4). `acc_code` shows the new value in the cycle after that strobe.
- R4: A strobe carrying a value that is neither the accepted code nor the current candidate restarts the count at one for that value.
- R5: A strobe whose pointer equals `acc_code` discards any pending candidate.
- R6: While `link_synced` is low, the pending count is cleared and `acc_code` is held.
- R7: `preload_en` loads `preload_code` into `acc_code` in the next cycle and discards any pending candidate, without a change pulse. It takes priority over a strobe in the same cycle.
- R8: Codes 1 to 6 decode to 240, 480, 960, 1920, 2400 and 3840 kbps. Each needs a minimum line-rate index: codes 1 and 2 need 0, code 3 needs 1, code 4 needs 2, code 5 needs 3, code 6 needs 4.
- R9: Code 7 decodes to the top rate for the line-rate index: index 0 to 6 give 480, 960, 1920, 2400, 3840, 4800 and 7680 kbps. Index 7 is treated as 6.
- R10: When the line-rate index is below the code's minimum, `unsupported` is high and `rate_kbps` is 0.
- R11: Code 0 means no channel: `chan_en` is low and `rate_kbps` is 0. Any other code raises `chan_en`.
- R12: `change_pulse` is high for exactly one cycle: the cycle in which `acc_code` first shows a value adopted through R3.
- R13: `acc_code` changes only after a synced strobe or a preload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hf_strobe | input | 1 | One cycle per hyperframe, qualifies `ctrl_byte` |
| ctrl_byte | input | 8 | Control byte carrying the rate pointer in [2:0] |
| link_synced | input | 1 | Hyperframe sync status |
| line_rate_sel | input | 3 | Line-rate index, ascending (0 = slowest) |
| preload_en | input | 1 | Software load of the starting code |
| preload_code | input | 3 | Code to load |
| acc_code | output | 3 | Accepted rate code |
| rate_kbps | output | 13 | Decoded channel rate in kbps |
| chan_en | output | 1 | Channel present |
| unsupported | output | 1 | Code needs a faster line |
| change_pulse | output | 1 | New code adopted |

## Verification
The bench builds the block with PERSIST at its default of 4. This keeps every adoption run only a few strobes long, so the bench can reach the following cases:
- three-strobe runs that must not be adopted;
- interrupted runs;
- runs broken by the accepted value or by loss of sync.

The 3-bit line-rate selector lets the bench sweep all seven line rates, plus the out-of-range index 7, against every code. This covers the top-code resolution and every unsupported boundary.

// File: rtl/slowctl_pkg.sv
package slowctl_pkg;
  localparam int PTR_W    = 3;
  localparam int LR_W     = 3;
  localparam int RATE_W   = 13;
  localparam int LR_TOP   = 6;
  typedef logic [PTR_W-1:0]  code_t;
  typedef logic [LR_W-1:0]   lr_t;
  typedef logic [RATE_W-1:0] rate_t;
endpackage

// File: rtl/slowctl_persist.sv
module slowctl_persist
  import slowctl_pkg::*;
#(
  parameter int PERSIST = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  strobe,
  input  code_t ptr,
  input  logic  synced,
  input  logic  preload_en,
  input  code_t preload_code,
  output code_t acc_code,
  output logic  accept_pulse
);
  localparam int CNT_W = $clog2(PERSIST + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERSIST - 1);

  code_t            cand;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_code     <= '0;
      cand         <= '0;
      cnt          <= '0;
      accept_pulse <= 1'b0;
    end else begin
      accept_pulse <= 1'b0;
      if (preload_en) begin
        acc_code <= preload_code;
        cnt      <= '0;
      end else if (!synced) begin
        cnt <= '0;
      end else if (strobe) begin
        if (ptr == acc_code) begin
          cnt <= '0;
        end else if (cnt != '0 && ptr == cand) begin
          if (cnt == LAST) begin
            acc_code     <= ptr;
            cnt          <= '0;
            accept_pulse <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else begin
          cand <= ptr;
          cnt  <= CNT_W'(1);
        end
      end
    end
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(PERSIST));

  p_nosync_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!synced && !preload_en) |=> $stable(acc_code));

  p_preload_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    preload_en |=> (acc_code == $past(preload_code) && !accept_pulse));
endmodule

// File: rtl/slowctl_decode.sv
module slowctl_decode
  import slowctl_pkg::*;
(
  input  code_t code,
  input  lr_t   line_sel,
  output rate_t rate_kbps,
  output logic  chan_en,
  output logic  unsupported
);
  lr_t   lr_eff;
  lr_t   min_lr;
  rate_t raw;

  always_comb begin
    lr_eff = (line_sel > lr_t'(LR_TOP)) ? lr_t'(LR_TOP) : line_sel;
    unique case (code)
      3'd1:    begin raw = rate_t'(240);  min_lr = 3'd0; end
      3'd2:    begin raw = rate_t'(480);  min_lr = 3'd0; end
      3'd3:    begin raw = rate_t'(960);  min_lr = 3'd1; end
      3'd4:    begin raw = rate_t'(1920); min_lr = 3'd2; end
      3'd5:    begin raw = rate_t'(2400); min_lr = 3'd3; end
      3'd6:    begin raw = rate_t'(3840); min_lr = 3'd4; end
      3'd7: begin
        min_lr = 3'd0;
        unique case (lr_eff)
          3'd0:    raw = rate_t'(480);
          3'd1:    raw = rate_t'(960);
          3'd2:    raw = rate_t'(1920);
          3'd3:    raw = rate_t'(2400);
          3'd4:    raw = rate_t'(3840);
          3'd5:    raw = rate_t'(4800);
          default: raw = rate_t'(7680);
        endcase
      end
      default: begin raw = '0; min_lr = 3'd0; end
    endcase
    chan_en     = (code != '0);
    unsupported = (lr_eff < min_lr);
    rate_kbps   = unsupported ? '0 : raw;
  end
endmodule

// File: rtl/slowctl_rate_acq.sv
module slowctl_rate_acq
  import slowctl_pkg::*;
#(
  parameter int PERSIST = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hf_strobe,
  input  logic [7:0]  ctrl_byte,
  input  logic        link_synced,
  input  logic [2:0]  line_rate_sel,
  input  logic        preload_en,
  input  logic [2:0]  preload_code,
  output logic [2:0]  acc_code,
  output logic [12:0] rate_kbps,
  output logic        chan_en,
  output logic        unsupported,
  output logic        change_pulse
);
  code_t acc_q;

  slowctl_persist #(.PERSIST(PERSIST)) u_persist (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe       (hf_strobe),
    .ptr          (ctrl_byte[PTR_W-1:0]),
    .synced       (link_synced),
    .preload_en   (preload_en),
    .preload_code (preload_code),
    .acc_code     (acc_q),
    .accept_pulse (change_pulse)
  );

  slowctl_decode u_decode (
    .code        (acc_q),
    .line_sel    (line_rate_sel),
    .rate_kbps   (rate_kbps),
    .chan_en     (chan_en),
    .unsupported (unsupported)
  );

  assign acc_code = acc_q;

  p_quiet_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!hf_strobe && !preload_en) |=> $stable(acc_code));

  p_pulse_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    change_pulse |=> !change_pulse);

  p_pulse_moves_r12: assert property (@(posedge clk) disable iff (!rst_n)
    change_pulse |-> (acc_code != $past(acc_code)));

  p_unsup_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    unsupported |-> (rate_kbps == '0));

  p_off_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |-> (rate_kbps == '0));
endmodule

// File: tb/tb_slowctl_rate_acq.sv
module tb_slowctl_rate_acq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hf_strobe = 1'b0;
  logic [7:0]  ctrl_byte = '0;
  logic        link_synced = 1'b1;
  logic [2:0]  line_rate_sel = 3'd6;
  logic        preload_en = 1'b0;
  logic [2:0]  preload_code = '0;
  logic [2:0]  acc_code;
  logic [12:0] rate_kbps;
  logic        chan_en, unsupported, change_pulse;

  int checks = 0;
  int failures = 0;
  logic pulse_seen;

  always #2.5 clk = ~clk;

  slowctl_rate_acq #(.PERSIST(4)) dut (
    .clk(clk), .rst_n(rst_n), .hf_strobe(hf_strobe), .ctrl_byte(ctrl_byte),
    .link_synced(link_synced), .line_rate_sel(line_rate_sel),
    .preload_en(preload_en), .preload_code(preload_code),
    .acc_code(acc_code), .rate_kbps(rate_kbps), .chan_en(chan_en),
    .unsupported(unsupported), .change_pulse(change_pulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_hf(input logic [7:0] b);
    @(negedge clk);
    hf_strobe = 1'b1;
    ctrl_byte = b;
    @(negedge clk);
    hf_strobe = 1'b0;
    pulse_seen = change_pulse;
    @(negedge clk);
  endtask

  task automatic do_preload(input logic [2:0] c);
    @(negedge clk);
    preload_en = 1'b1;
    preload_code = c;
    @(negedge clk);
    preload_en = 1'b0;
    pulse_seen = change_pulse;
  endtask

  function automatic int exp_rate(input int code, input int lr);
    int l;
    int minl[8] = '{0, 0, 0, 1, 2, 3, 4, 0};
    int fixed[8] = '{0, 240, 480, 960, 1920, 2400, 3840, 0};
    int top[7] = '{480, 960, 1920, 2400, 3840, 4800, 7680};
    l = (lr > 6) ? 6 : lr;
    if (l < minl[code]) return 0;
    if (code == 7) return top[l];
    return fixed[code];
  endfunction

  task automatic t_reset;
    chk("R2 acc", acc_code, 0);
    chk("R2 chan_en", chan_en, 0);
    chk("R2 rate", rate_kbps, 0);
    chk("R2 unsupported", unsupported, 0);
    chk("R2 pulse", change_pulse, 0);
  endtask

  task automatic t_persist;
    for (int i = 0; i < 3; i++) begin
      send_hf(8'hF9);
      chk("R3 not yet adopted", acc_code, 0);
      chk("R12 no pulse early", pulse_seen, 0);
    end
    send_hf(8'h01);
    chk("R3 adopted on fourth", acc_code, 1);
    chk("R12 pulse on adoption", pulse_seen, 1);
    @(negedge clk);
    chk("R12 pulse one cycle", change_pulse, 0);
    chk("R1 upper bits ignored", acc_code, 1);
  endtask

  task automatic t_restart;
    send_hf(8'h02); send_hf(8'h02); send_hf(8'h03);
    send_hf(8'h02); send_hf(8'h02); send_hf(8'h02);
    chk("R4 restart holds", acc_code, 1);
    send_hf(8'h02);
    chk("R4 adopted after restart", acc_code, 2);
  endtask

  task automatic t_accepted_clears;
    send_hf(8'h05); send_hf(8'h05); send_hf(8'h05);
    send_hf(8'h02);
    send_hf(8'h05); send_hf(8'h05); send_hf(8'h05);
    chk("R5 pending discarded", acc_code, 2);
    send_hf(8'h05);
    chk("R5 adopted after fresh run", acc_code, 5);
  endtask

  task automatic t_sync_loss;
    send_hf(8'h03); send_hf(8'h03); send_hf(8'h03);
    link_synced = 1'b0;
    send_hf(8'h03);
    chk("R6 held during sync loss", acc_code, 5);
    link_synced = 1'b1;
    send_hf(8'h03); send_hf(8'h03); send_hf(8'h03);
    chk("R6 count was cleared", acc_code, 5);
    send_hf(8'h03);
    chk("R6 adopted after resync", acc_code, 3);
  endtask

  task automatic t_preload;
    send_hf(8'h04); send_hf(8'h04); send_hf(8'h04);
    do_preload(3'd6);
    chk("R7 preload value", acc_code, 6);
    chk("R7 no pulse", pulse_seen, 0);
    send_hf(8'h04);
    chk("R7 pending discarded", acc_code, 6);
    @(negedge clk);
    preload_en = 1'b1; preload_code = 3'd2;
    hf_strobe = 1'b1; ctrl_byte = 8'h04;
    @(negedge clk);
    preload_en = 1'b0; hf_strobe = 1'b0;
    chk("R7 priority over strobe", acc_code, 2);
  endtask

  task automatic t_decode;
    line_rate_sel = 3'd6;
    for (int c = 1; c <= 6; c++) begin
      do_preload(3'(c));
      chk("R8 rate", rate_kbps, exp_rate(c, 6));
      chk("R11 enabled", chan_en, 1);
    end
    do_preload(3'd0);
    chk("R11 disabled", chan_en, 0);
    chk("R11 rate zero", rate_kbps, 0);
    do_preload(3'd7);
    for (int l = 0; l < 8; l++) begin
      line_rate_sel = 3'(l);
      #1;
      chk("R9 top rate", rate_kbps, exp_rate(7, l));
      chk("R9 supported", unsupported, 0);
    end
    for (int c = 1; c <= 6; c++) begin
      do_preload(3'(c));
      for (int l = 0; l < 8; l++) begin
        line_rate_sel = 3'(l);
        #1;
        chk("R10 rate", rate_kbps, exp_rate(c, l));
        chk("R10 flag", unsupported, (exp_rate(c, l) == 0) ? 1 : 0);
      end
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_persist();
    t_restart();
    t_accepted_clears();
    t_sync_loss();
    t_preload();
    t_decode();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule